// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames one byte at a time and stores them in memory buffers. A ring of descriptors in memory describes those buffers. For each buffer it reads the current descriptor and checks who owns it. It then writes frame bytes into the buffer until the buffer is full or the frame ends. Next it rewrites the descriptor with frame status and hands it back to software. Finally it moves on to the next descriptor in the ring, either by a fixed stride or by returning to the ring base when the descriptor is marked as the last in the ring.

The byte input is a valid/ready stream. A byte is taken only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` does not depend on `s_valid`, and it stays low while descriptors are being read or written back. A sender may hold a byte for any number of cycles.

Address matching is done upstream. Its results arrive on the `rx_*` flag pins, which must stay stable from the first byte of a frame to its last. The configuration inputs must stay stable while a frame is in progress.

The memory port has these rules:
- It takes one access per cycle.
- Read data appears on `mem_rdata` one cycle after `mem_rd`.
- Writes use byte strobes, and bit lane b of the strobe covers byte address offset b.

Top module: `rxd_ring_writer`

## Requirements
- R1: A descriptor has 2 words, plus 2 when `cfg_addr64` is set, plus 2 when `cfg_ext_desc` is set. The words are read one at a time in ascending order from the descriptor address. The descriptor address has the 32-bit ring pointer as its low half. Its high half is `cfg_ring_hi` in 64-bit mode and zero otherwise.
- R2: The buffer address is descriptor word 0 with bits 1:0 forced to zero. In 64-bit mode word 2 supplies address bits 63:32; otherwise those bits are zero. The k-th byte placed in a buffer is written to buffer address + k. The write enables the single strobe lane given by address bits 1:0, and `mem_wdata` carries the byte in every lane.
- R3: A descriptor takes at most `cfg_buf_units` × 2^BUF_UNIT_SHIFT bytes (64-byte units by default). A value of zero means 256 units. A frame that does not fit continues in the next descriptor.
- R4: Word 1 is written back with these fields:
  - bit 14 set on the first descriptor of a frame.
  - on the last descriptor of a frame only: bit 15 set, bits 12:0 holding the total frame length, bit 31 broadcast, bit 30 multicast-hash, bit 29 unicast-hash, and bits 26:25 the specific-address index.
  - every other bit zero.
- R5: After the data writes for a descriptor, every active word is written back in ascending order with full strobes. Word 0 is written with bit 0 (ownership) set and its other bits unchanged. Words 2 and above are written back with the values that were read.
- R6: After write-back, the ring pointer is reloaded from `cfg_ring_base` when word 0 bit 1 (wrap) is set. Otherwise it advances by 4 × the word count.
- R7: A descriptor read with word 0 bit 0 already set belongs to software. No buffer is written for it and the ring pointer does not move. `evt_no_buf` pulses for one cycle. `irq_rx_used` pulses in the same cycle unless `cfg_used_irq_mask` is set. If this happens at the start of a frame, the whole frame is accepted and discarded.
- R8: If this happens on a later descriptor of a frame, `evt_overrun` also pulses. The rest of the frame is accepted and discarded, and descriptors already written back are left as they are.
- R9: No byte is accepted, and no byte write is issued, outside the buffer-filling phase. `mem_rd` and `mem_wr` are never high together.
- R10: After reset, `s_ready`, `mem_rd` and `mem_wr` are low. The first descriptor read after reset uses `cfg_ring_base` as the ring pointer.
- R11: `evt_frame_done` pulses for one cycle with the last write-back word of a frame that was fully stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Byte stream valid |
| s_ready | output | 1 | Byte stream ready |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the final byte of a frame |
| rx_bcast | input | 1 | Frame is broadcast |
| rx_mhash | input | 1 | Multicast hash match |
| rx_uhash | input | 1 | Unicast hash match |
| rx_sa_idx | input | 2 | Index of the matching specific address |
| cfg_addr64 | input | 1 | 64-bit descriptor addressing |
| cfg_ext_desc | input | 1 | Extended (two extra words) descriptors |
| cfg_buf_units | input | 8 | Buffer size in units |
| cfg_ring_base | input | 32 | Ring base, low 32 address bits |
| cfg_ring_hi | input | 32 | High 32 bits of descriptor addresses in 64-bit mode |
| cfg_used_irq_mask | input | 1 | Masks the used-descriptor interrupt |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 64 | Byte address of the access |
| mem_wstrb | output | 4 | Write byte strobes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| evt_no_buf | output | 1 | Pulse: descriptor owned by software |
| evt_overrun | output | 1 | Pulse: frame cut short for lack of buffers |
| irq_rx_used | output | 1 | Pulse: used-descriptor interrupt |
| evt_frame_done | output | 1 | Pulse: frame fully stored |

## Verification
The bench sets BUF_UNIT_SHIFT to 2, so one buffer unit is four bytes. With that setting, frames of a few bytes fill a buffer, split across two descriptors and run into a software-owned descriptor partway through. It also makes the zero-units case (1024 bytes) easy to check against a short frame. LEN_W keeps its default of 13. Across successive frames the bench switches between 2-, 4- and 6-word descriptors, so each stride, the wrap reload and the masking of word 2 by the addressing mode are all observed on the memory port.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FWAIT, ST_CHECK, ST_DATA, ST_WB, ST_DROP
  } rxd_state_e;

  // word 0 control bits (software decodes them)
  localparam int unsigned OWN_BIT   = 0;
  localparam int unsigned WRAP_BIT  = 1;
  // word 1 status bits (software decodes them)
  localparam int unsigned SOF_BIT   = 14;
  localparam int unsigned EOF_BIT   = 15;
  localparam int unsigned SA_LO_BIT = 25;
  localparam int unsigned UHASH_BIT = 29;
  localparam int unsigned MHASH_BIT = 30;
  localparam int unsigned BCAST_BIT = 31;

  typedef struct packed {
    logic       bcast;
    logic       mhash;
    logic       uhash;
    logic [1:0] sa_idx;
  } rxd_flags_t;
endpackage

// File: rtl/rxd_desc_fmt.sv
module rxd_desc_fmt
  import rxd_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic             addr64,
  input  logic             ext,
  input  logic [31:0]      word0,
  input  logic [31:0]      word2,
  input  logic [31:0]      ring_hi,
  input  logic [31:0]      ring_ptr,
  input  logic [31:0]      ring_base,
  input  logic             sof,
  input  logic             eof,
  input  logic [LEN_W-1:0] frame_len,
  input  rxd_flags_t       flags,
  output logic [2:0]       nwords,
  output logic [63:0]      desc_addr,
  output logic [63:0]      buf_addr,
  output logic [31:0]      next_ptr,
  output logic [31:0]      wb_word0,
  output logic [31:0]      status_word
);
  always_comb begin
    nwords    = 3'd2 + (addr64 ? 3'd2 : 3'd0) + (ext ? 3'd2 : 3'd0);
    desc_addr = {(addr64 ? ring_hi : 32'h0), ring_ptr};
    buf_addr  = {(addr64 ? word2 : 32'h0), word0[31:2], 2'b00};
    next_ptr  = word0[WRAP_BIT] ? ring_base : ring_ptr + {27'd0, nwords, 2'b00};
    wb_word0  = word0;
    wb_word0[OWN_BIT] = 1'b1;
    status_word = '0;
    status_word[SOF_BIT] = sof;
    if (eof) begin
      status_word[EOF_BIT]         = 1'b1;
      status_word[LEN_W-1:0]       = frame_len;
      status_word[BCAST_BIT]       = flags.bcast;
      status_word[MHASH_BIT]       = flags.mhash;
      status_word[UHASH_BIT]       = flags.uhash;
      status_word[SA_LO_BIT +: 2]  = flags.sa_idx;
    end
  end
endmodule

// File: rtl/rxd_buf_cnt.sv
module rxd_buf_cnt #(
  parameter int UNITS_W    = 8,
  parameter int UNIT_SHIFT = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          inc,
  input  logic [UNITS_W-1:0]            units,
  output logic [UNITS_W+UNIT_SHIFT:0]   offset,
  output logic                          at_last
);
  localparam int OFF_W = UNITS_W + UNIT_SHIFT + 1;

  logic [OFF_W-1:0] limit;

  always_comb begin
    limit = '0;
    if (units == '0) limit[OFF_W-1] = 1'b1;
    else             limit[OFF_W-2:UNIT_SHIFT] = units;
    at_last = (offset == limit - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   offset <= '0;
    else if (clr) offset <= '0;
    else if (inc) offset <= offset + 1'b1;
  end

  assert_cnt_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (offset < limit));
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
  import rxd_pkg::*;
#(
  parameter int BUF_UNITS_W    = 8,
  parameter int BUF_UNIT_SHIFT = 6,
  parameter int LEN_W          = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [7:0]             s_data,
  input  logic                   s_last,
  input  logic                   rx_bcast,
  input  logic                   rx_mhash,
  input  logic                   rx_uhash,
  input  logic [1:0]             rx_sa_idx,
  input  logic                   cfg_addr64,
  input  logic                   cfg_ext_desc,
  input  logic [BUF_UNITS_W-1:0] cfg_buf_units,
  input  logic [31:0]            cfg_ring_base,
  input  logic [31:0]            cfg_ring_hi,
  input  logic                   cfg_used_irq_mask,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic [63:0]            mem_addr,
  output logic [3:0]             mem_wstrb,
  output logic [31:0]            mem_wdata,
  input  logic [31:0]            mem_rdata,
  output logic                   evt_no_buf,
  output logic                   evt_overrun,
  output logic                   irq_rx_used,
  output logic                   evt_frame_done
);
  localparam int OFF_W      = BUF_UNITS_W + BUF_UNIT_SHIFT + 1;
  localparam int IDX_W      = 3;
  localparam int DESC_SLOTS = 1 << IDX_W;

  rxd_state_e       state_q;
  logic [31:0]      ptr_q;
  logic             ptr_ok_q;
  logic [31:0]      desc_q [DESC_SLOTS];
  logic [IDX_W-1:0] widx_q;
  logic             first_q, eof_q;
  logic [LEN_W-1:0] flen_q;
  rxd_flags_t       flags_q;

  logic [2:0]       nwords;
  logic [63:0]      desc_addr, buf_addr, byte_addr, word_addr;
  logic [31:0]      next_ptr, wb_word0, status_word;
  logic [OFF_W-1:0] offset;
  logic             at_last, cnt_clr, cnt_inc, last_word;

  rxd_desc_fmt #(.LEN_W(LEN_W)) i_fmt (
    .addr64(cfg_addr64), .ext(cfg_ext_desc), .word0(desc_q[0]), .word2(desc_q[2]),
    .ring_hi(cfg_ring_hi), .ring_ptr(ptr_q), .ring_base(cfg_ring_base),
    .sof(first_q), .eof(eof_q), .frame_len(flen_q), .flags(flags_q),
    .nwords(nwords), .desc_addr(desc_addr), .buf_addr(buf_addr),
    .next_ptr(next_ptr), .wb_word0(wb_word0), .status_word(status_word)
  );

  rxd_buf_cnt #(.UNITS_W(BUF_UNITS_W), .UNIT_SHIFT(BUF_UNIT_SHIFT)) i_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .units(cfg_buf_units), .offset(offset), .at_last(at_last)
  );

  assign byte_addr = buf_addr + {{(64-OFF_W){1'b0}}, offset};
  assign word_addr = desc_addr + {59'd0, widx_q, 2'b00};
  assign last_word = (widx_q == nwords - 3'd1);

  always_comb begin
    s_ready = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0;
    mem_addr = '0; mem_wstrb = '0; mem_wdata = '0;
    evt_no_buf = 1'b0; evt_overrun = 1'b0; irq_rx_used = 1'b0; evt_frame_done = 1'b0;
    cnt_clr = 1'b0; cnt_inc = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = word_addr;
      end
      ST_CHECK: begin
        cnt_clr = 1'b1;
        if (desc_q[0][OWN_BIT]) begin
          evt_no_buf  = 1'b1;
          irq_rx_used = !cfg_used_irq_mask;
          evt_overrun = !first_q;
        end
      end
      ST_DATA: begin
        s_ready = 1'b1;
        if (s_valid) begin
          mem_wr    = 1'b1;
          mem_addr  = byte_addr;
          mem_wstrb = 4'b0001 << byte_addr[1:0];
          mem_wdata = {4{s_data}};
          cnt_inc   = 1'b1;
        end
      end
      ST_WB: begin
        mem_wr    = 1'b1;
        mem_addr  = word_addr;
        mem_wstrb = 4'hF;
        if (widx_q == '0)               mem_wdata = wb_word0;
        else if (widx_q == IDX_W'(1))   mem_wdata = status_word;
        else                            mem_wdata = desc_q[widx_q];
        evt_frame_done = last_word && eof_q;
      end
      ST_DROP: s_ready = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      ptr_ok_q <= 1'b0;
      widx_q   <= '0;
      first_q  <= 1'b0;
      eof_q    <= 1'b0;
      flen_q   <= '0;
      flags_q  <= '0;
      for (int i = 0; i < DESC_SLOTS; i++) desc_q[i] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (s_valid) begin
          state_q <= ST_FETCH;
          widx_q  <= '0;
          first_q <= 1'b1;
          eof_q   <= 1'b0;
          flen_q  <= '0;
          flags_q <= '{bcast: rx_bcast, mhash: rx_mhash, uhash: rx_uhash, sa_idx: rx_sa_idx};
          if (!ptr_ok_q) begin
            ptr_q    <= cfg_ring_base;
            ptr_ok_q <= 1'b1;
          end
        end
        ST_FETCH: state_q <= ST_FWAIT;
        ST_FWAIT: begin
          desc_q[widx_q] <= mem_rdata;
          if (last_word) state_q <= ST_CHECK;
          else begin
            widx_q  <= widx_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_CHECK: state_q <= desc_q[0][OWN_BIT] ? ST_DROP : ST_DATA;
        ST_DATA: if (s_valid) begin
          flen_q <= flen_q + 1'b1;
          if (s_last || at_last) begin
            eof_q   <= s_last;
            widx_q  <= '0;
            state_q <= ST_WB;
          end
        end
        ST_WB: begin
          if (last_word) begin
            ptr_q   <= next_ptr;
            first_q <= 1'b0;
            widx_q  <= '0;
            state_q <= eof_q ? ST_IDLE : ST_FETCH;
          end else begin
            widx_q <= widx_q + 1'b1;
          end
        end
        ST_DROP: if (s_valid && s_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_byte_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_wstrb != 4'hF) |-> (s_valid && s_ready));
  assert_single_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_wstrb != 4'hF) |-> ($countones(mem_wstrb) == 1));
  assert_wb_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB && widx_q == '0) |-> (mem_wr && mem_wdata[OWN_BIT]));
  assert_irq_needs_nobuf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_used |-> evt_no_buf);
  assert_overrun_needs_nobuf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |-> evt_no_buf);
  assert_quiet_before_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_ok_q |-> (!mem_rd && !mem_wr && !s_ready));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_done |=> !evt_frame_done);
endmodule

// File: tb/test_rxd_ring_writer.sv
`timescale 1ns/1ps
module test_rxd_ring_writer;
  localparam int SHIFT = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, s_valid, s_ready, s_last;
  logic [7:0] s_data;
  logic rx_bcast, rx_mhash, rx_uhash;
  logic [1:0] rx_sa_idx;
  logic cfg_addr64, cfg_ext_desc, cfg_used_irq_mask;
  logic [7:0] cfg_buf_units;
  logic [31:0] cfg_ring_base, cfg_ring_hi;
  logic mem_rd, mem_wr;
  logic [63:0] mem_addr;
  logic [3:0] mem_wstrb;
  logic [31:0] mem_wdata, mem_rdata;
  logic evt_no_buf, evt_overrun, irq_rx_used, evt_frame_done;

  rxd_ring_writer #(.BUF_UNIT_SHIFT(SHIFT)) i_rxd_ring_writer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .rx_bcast(rx_bcast), .rx_mhash(rx_mhash), .rx_uhash(rx_uhash),
    .rx_sa_idx(rx_sa_idx), .cfg_addr64(cfg_addr64), .cfg_ext_desc(cfg_ext_desc),
    .cfg_buf_units(cfg_buf_units), .cfg_ring_base(cfg_ring_base), .cfg_ring_hi(cfg_ring_hi),
    .cfg_used_irq_mask(cfg_used_irq_mask), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .evt_no_buf(evt_no_buf), .evt_overrun(evt_overrun), .irq_rx_used(irq_rx_used),
    .evt_frame_done(evt_frame_done)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle read latency, strobed writes
  logic [31:0] mem [0:1023];
  function automatic int idx(logic [63:0] a);
    return int'(a[11:2]);
  endfunction
  always @(posedge clk) begin
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_wstrb[b]) mem[idx(mem_addr)][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_rd) mem_rdata <= mem[idx(mem_addr)];
  end

  // scoreboard
  typedef struct {
    bit          wr;
    logic [63:0] addr;
    logic [3:0]  strb;
    logic [31:0] data;
    string       tag;
  } op_t;
  op_t expq[$];
  op_t got;

  task automatic push(bit wr, logic [63:0] a, logic [3:0] s, logic [31:0] d, string t);
    op_t o;
    o.wr = wr; o.addr = a; o.strb = s; o.data = d; o.tag = t;
    expq.push_back(o);
  endtask

  int a_nobuf = 0, a_irq = 0, a_ovr = 0, a_done = 0;
  int e_nobuf = 0, e_irq = 0, e_ovr = 0, e_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_no_buf) a_nobuf++;
      if (irq_rx_used) a_irq++;
      if (evt_overrun) a_ovr++;
      if (evt_frame_done) a_done++;
      if (mem_rd || mem_wr) begin
        if (expq.size() == 0) begin
          chk(0, "R9", "unexpected memory access", mem_addr, 0);
        end else begin
          got = expq.pop_front();
          chk(got.wr == mem_wr && got.addr == mem_addr &&
              (!got.wr || (got.strb == mem_wstrb && got.data == mem_wdata)),
              got.tag, mem_wr ? "write addr/data" : "read addr",
              mem_wr ? {mem_addr[31:0], mem_wdata} : mem_addr,
              got.wr ? {got.addr[31:0], got.data} : got.addr);
        end
      end
    end
  end

  // reference model of the ring, built from the requirements
  logic [31:0] m_ptr;
  bit m_ok = 0;

  task automatic model_frame(int n, logic [7:0] seed);
    int off = 0;
    bit first = 1;
    bit last;
    int cnt, lim;
    logic [63:0] da, ba, a;
    logic [31:0] w0, w1, wv;
    logic [7:0] b;
    if (!m_ok) begin m_ptr = cfg_ring_base; m_ok = 1; end
    cnt = 2 + (cfg_addr64 ? 2 : 0) + (cfg_ext_desc ? 2 : 0);
    lim = ((cfg_buf_units == 0) ? 256 : int'(cfg_buf_units)) * (1 << SHIFT);
    forever begin
      da = {(cfg_addr64 ? cfg_ring_hi : 32'h0), m_ptr};
      for (int i = 0; i < cnt; i++) push(0, da + 64'(4*i), 4'h0, 32'h0, "R1 R6 R10 fetch");
      w0 = mem[idx(da)];
      if (w0[0]) begin
        e_nobuf++;
        if (!cfg_used_irq_mask) e_irq++;
        if (!first) e_ovr++;
        break;
      end
      ba = {(cfg_addr64 ? mem[idx(da + 64'd8)] : 32'h0), w0[31:2], 2'b00};
      for (int k = 0; k < lim && off < n; k++) begin
        a = ba + 64'(k);
        b = seed + 8'(off);
        push(1, a, 4'b0001 << a[1:0], {4{b}}, "R2 R3 data");
        off++;
      end
      last = (off == n);
      w1 = 32'h0;
      w1[14] = first;
      if (last) begin
        w1[15] = 1'b1; w1[12:0] = 13'(n);
        w1[31] = rx_bcast; w1[30] = rx_mhash; w1[29] = rx_uhash; w1[26:25] = rx_sa_idx;
      end
      for (int i = 0; i < cnt; i++) begin
        wv = (i == 0) ? (w0 | 32'h1) : (i == 1) ? w1 : mem[idx(da + 64'(4*i))];
        push(1, da + 64'(4*i), 4'hF, wv, (i == 1) ? "R4 status" : "R5 writeback");
      end
      m_ptr = w0[1] ? cfg_ring_base : m_ptr + 32'(4*cnt);
      first = 0;
      if (last) begin e_done++; break; end
    end
  endtask

  task automatic send_frame(int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = seed + 8'(i); s_last = (i == n-1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic run_frame(int n, logic [7:0] seed, logic bc, logic mh, logic uh, logic [1:0] sa);
    rx_bcast = bc; rx_mhash = mh; rx_uhash = uh; rx_sa_idx = sa;
    model_frame(n, seed);
    send_frame(n, seed);
    repeat (40) @(negedge clk);
    chk(expq.size() == 0, "R5", "expected accesses left over", 0, expq.size());
    chk(a_nobuf == e_nobuf, "R7", "no-buffer events", a_nobuf, e_nobuf);
    chk(a_irq == e_irq, "R7", "used interrupts", a_irq, e_irq);
    chk(a_ovr == e_ovr, "R8", "overrun events", a_ovr, e_ovr);
    chk(a_done == e_done, "R11", "frame done pulses", a_done, e_done);
    chk(!s_ready, "R9", "ready while idle", s_ready, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "WATCHDOG", "run did not finish", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    rx_bcast = 0; rx_mhash = 0; rx_uhash = 0; rx_sa_idx = '0;
    cfg_addr64 = 0; cfg_ext_desc = 0; cfg_buf_units = 8'd2;
    cfg_ring_base = 32'h100; cfg_ring_hi = 32'h0; cfg_used_irq_mask = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    mem[32'h100 >> 2] = 32'h400;
    mem[32'h108 >> 2] = 32'h500;
    mem[32'h110 >> 2] = 32'h602;           // wrap set
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_ready && !mem_rd && !mem_wr, "R10", "quiet after reset",
        {s_ready, mem_rd, mem_wr}, 0);

    // R1 R4: single-descriptor frame, 32-bit mode
    run_frame(5, 8'h10, 1, 0, 0, 2'd2);
    // R3 R6: frame spanning two descriptors, then wrap to base
    run_frame(13, 8'h40, 0, 1, 1, 2'd0);
    // R7: software-owned descriptor at frame start, then with interrupt masked
    run_frame(4, 8'h70, 0, 0, 0, 2'd0);
    cfg_used_irq_mask = 1;
    run_frame(3, 8'h80, 0, 0, 0, 2'd1);
    cfg_used_irq_mask = 0;
    // R8: ring runs out partway through a frame
    mem[32'h100 >> 2] = 32'h400;
    run_frame(12, 8'h90, 1, 0, 0, 2'd3);
    // R1 R2 R5 R6: 64-bit extended descriptors, wrap to new base
    cfg_addr64 = 1; cfg_ext_desc = 1; cfg_ring_hi = 32'hA; cfg_ring_base = 32'h200;
    mem[32'h108 >> 2] = 32'h702; mem[(32'h108 >> 2) + 1] = 32'h0;
    mem[(32'h108 >> 2) + 2] = 32'h5; mem[(32'h108 >> 2) + 3] = 32'h0;
    mem[(32'h108 >> 2) + 4] = 32'h1111; mem[(32'h108 >> 2) + 5] = 32'h2222;
    run_frame(3, 8'hA0, 0, 0, 1, 2'd1);
    // R3 R6: 4-byte buffers, stride of 24 bytes
    cfg_buf_units = 8'd1;
    mem[32'h200 >> 2] = 32'h800;
    mem[32'h218 >> 2] = 32'h900;
    run_frame(6, 8'hB0, 1, 1, 0, 2'd0);
    // R1 R2 R3: extended without 64-bit (stride 16), word 2 ignored, zero units
    cfg_addr64 = 0; cfg_buf_units = 8'd0;
    mem[32'h230 >> 2] = 32'hA00; mem[(32'h230 >> 2) + 2] = 32'hFFFF;
    run_frame(20, 8'hC0, 0, 0, 0, 2'd3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule